// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides, for each fully received CAN frame, whether its identifier is wanted and which receive buffer should take it. It holds six programmable filter registers and two mask registers. Each filter carries an identifier value and a flag that marks it as a standard (11-bit) or an extended (29-bit) filter. Each mask bit selects whether the matching identifier bit is examined (1) or ignored (0).

When the receiver asserts a one-cycle strobe with a complete identifier, all six filters compare in parallel. The lowest-numbered enabled filter that matches is reported together with a destination. In legacy mode the destination is fixed by the filter's group. In FIFO mode any enabled filter may accept, and the destination is the next slot of an eight-entry receive ring. Storing the frame and draining the ring belong to other blocks.

Top module: `id_accept_filter`

## Requirements
- R1: After reset, acc_pulse, acc_filt, acc_buf and the ring write slot are all 0, and every filter and mask register reads as 0.
- R2: A write with wr_en high stores wr_data into the register that wr_addr selects. Addresses 0 to 5 are filters, where bit 29 is the extended flag and bits 28:0 are the identifier. Address 6 is mask 0 and address 7 is mask 1, each using bits 28:0.
- R3: An identifier bit whose mask bit is 0 never causes a rejection, whatever its filter and identifier values are.
- R4: An identifier bit whose mask bit is 1 is accepted only when it equals the filter bit. A single unequal bit makes that filter miss.
- R5: A standard identifier sits in msg_id[28:18], and msg_id[17:0] is not compared. An extended identifier compares all 29 bits.
- R6: A filter matches only when its extended flag equals msg_ext.
- R7: A filter whose filt_en bit is 0 never matches.
- R8: When several filters match, acc_filt reports the lowest index.
- R9: The result is registered. acc_pulse is high for exactly the one cycle after a msg_valid cycle that produced a match, and it is never high otherwise.
- R10: Filters 0 and 1 are compared under mask 0, and filters 2 to 5 under mask 1, in both modes. In legacy mode (fifo_mode=0), filters 0 and 1 deliver to buffer 0 and filters 2 to 5 deliver to buffer 1.
- R11: In FIFO mode (fifo_mode=1), acc_buf is the current ring write slot. The slot advances by one on each FIFO-mode acceptance, wraps from 7 to 0, and does not move on a rejection or on a legacy-mode acceptance.
- R12: acc_filt and acc_buf keep their last accepted values through cycles with no acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0-5 filters, 6-7 masks |
| wr_data | input | 30 | Write data: bit 29 extended flag, bits 28:0 identifier or mask |
| fifo_mode | input | 1 | 0 legacy grouped routing, 1 FIFO ring routing |
| filt_en | input | 6 | Per-filter enable |
| msg_valid | input | 1 | One-cycle strobe: complete identifier present |
| msg_ext | input | 1 | Identifier is extended (29-bit) |
| msg_id | input | 29 | Received identifier, standard in bits 28:18 |
| acc_pulse | output | 1 | Acceptance pulse, one cycle after the strobe |
| acc_filt | output | 3 | Index of the accepting filter |
| acc_buf | output | 3 | Destination buffer or ring slot |

## Verification
The bench builds the block with its default parameters: 29-bit identifiers, six filters, and an eight-slot ring. At that size, every single-bit identifier flip can be swept under full and single-bit-cleared masks for both identifier widths. All 64 enable patterns are run against identical filters in both modes, which covers every priority outcome and both routing groups. More than eight FIFO acceptances reach the ring wrap, and a pseudo-random stream mixes near-hits and misses against a bench-side arithmetic model.

// File: rtl/idf_pkg.sv
package idf_pkg;
  // Width of a standard identifier, left-aligned in the identifier field
  localparam int STD_W = 11;
  // Number of mask registers (two filter groups)
  localparam int NUM_MASK = 2;
  typedef enum logic {
    MODE_LEGACY = 1'b0,
    MODE_FIFO   = 1'b1
  } rx_mode_e;
endpackage

// File: rtl/idf_regs.sv
module idf_regs #(
  parameter int ID_W = 29,
  parameter int NUM_FILT = 6,
  localparam int AW = $clog2(NUM_FILT + idf_pkg::NUM_MASK)
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      wr_en,
  input  logic [AW-1:0]                             wr_addr,
  input  logic [ID_W:0]                             wr_data,
  output logic [NUM_FILT-1:0][ID_W:0]               filt_q,
  output logic [idf_pkg::NUM_MASK-1:0][ID_W-1:0]    mask_q
);
  for (genvar k = 0; k < NUM_FILT; k++) begin : g_filt
    always_ff @(posedge clk) begin
      if (rst)                                 filt_q[k] <= '0;
      else if (wr_en && wr_addr == AW'(k))     filt_q[k] <= wr_data;
    end

    // R2
    filt_wr_chk: assert property (@(posedge clk) disable iff (rst)
      $past(wr_en && !rst && wr_addr == AW'(k)) |-> filt_q[k] == $past(wr_data));
  end

  for (genvar m = 0; m < idf_pkg::NUM_MASK; m++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst)                                        mask_q[m] <= '0;
      else if (wr_en && wr_addr == AW'(NUM_FILT + m)) mask_q[m] <= wr_data[ID_W-1:0];
    end

    // R2
    mask_wr_chk: assert property (@(posedge clk) disable iff (rst)
      $past(wr_en && !rst && wr_addr == AW'(NUM_FILT + m)) |-> mask_q[m] == $past(wr_data[ID_W-1:0]));
  end
endmodule

// File: rtl/idf_match.sv
module idf_match #(
  parameter int ID_W = 29,
  parameter int NUM_FILT = 6,
  parameter int GRP0_FILTS = 2
) (
  input  logic [NUM_FILT-1:0][ID_W:0]               filt_q,
  input  logic [idf_pkg::NUM_MASK-1:0][ID_W-1:0]    mask_q,
  input  logic [NUM_FILT-1:0]                       filt_en,
  input  logic                                      msg_ext,
  input  logic [ID_W-1:0]                           msg_id,
  output logic [NUM_FILT-1:0]                       hit
);
  localparam logic [ID_W-1:0] STD_SEL =
    {{idf_pkg::STD_W{1'b1}}, {(ID_W - idf_pkg::STD_W){1'b0}}};

  logic [ID_W-1:0] cmp_sel;
  assign cmp_sel = msg_ext ? '1 : STD_SEL;

  for (genvar k = 0; k < NUM_FILT; k++) begin : g_cmp
    localparam int MI = (k < GRP0_FILTS) ? 0 : 1;
    logic [ID_W-1:0] miss_bits;
    assign miss_bits = (msg_id ^ filt_q[k][ID_W-1:0]) & mask_q[MI] & cmp_sel;
    assign hit[k] = filt_en[k] && (filt_q[k][ID_W] == msg_ext) && (miss_bits == '0);
  end
endmodule

// File: rtl/idf_route.sv
module idf_route #(
  parameter int NUM_FILT = 6,
  parameter int FIFO_DEPTH = 8,
  parameter int GRP0_FILTS = 2,
  localparam int FW = $clog2(NUM_FILT),
  localparam int BW = $clog2(FIFO_DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                msg_valid,
  input  logic                fifo_mode,
  input  logic [NUM_FILT-1:0] filt_en,
  input  logic [NUM_FILT-1:0] hit,
  output logic                acc_pulse,
  output logic [FW-1:0]       acc_filt,
  output logic [BW-1:0]       acc_buf
);
  logic [FW-1:0] win_idx;
  logic          any_hit;
  logic          take;
  logic          fifo_take;
  logic [BW-1:0] wslot;
  logic [BW-1:0] grp_buf;

  // Lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    win_idx = '0;
    for (int k = NUM_FILT - 1; k >= 0; k--) begin
      if (hit[k]) win_idx = FW'(k);
    end
  end

  assign any_hit   = |hit;
  assign take      = msg_valid && any_hit;
  assign fifo_take = take && (fifo_mode == idf_pkg::MODE_FIFO);
  assign grp_buf   = (win_idx >= FW'(GRP0_FILTS)) ? BW'(1) : BW'(0);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_pulse <= 1'b0;
      acc_filt  <= '0;
      acc_buf   <= '0;
      wslot     <= '0;
    end else begin
      acc_pulse <= take;
      if (take) begin
        acc_filt <= win_idx;
        acc_buf  <= fifo_mode ? wslot : grp_buf;
      end
      if (fifo_take) begin
        wslot <= (wslot == BW'(FIFO_DEPTH - 1)) ? '0 : wslot + BW'(1);
      end
    end
  end

  // R9
  acc_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    acc_pulse |-> $past(msg_valid));

  // R7
  acc_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    acc_pulse |-> ((($past(filt_en)) >> acc_filt) & NUM_FILT'(1)) != '0);

  // R10
  legacy_buf_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_pulse && !$past(fifo_mode)) |->
      acc_buf == ((acc_filt >= FW'(GRP0_FILTS)) ? BW'(1) : BW'(0)));

  // R11
  ring_step_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fifo_take && !rst) |->
      wslot == (($past(wslot) == BW'(FIFO_DEPTH - 1)) ? BW'(0) : $past(wslot) + BW'(1)));

  // R11
  ring_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!fifo_take && !rst) |-> $stable(wslot));
endmodule

// File: rtl/id_accept_filter.sv
module id_accept_filter #(
  parameter int ID_W = 29,
  parameter int NUM_FILT = 6,
  parameter int FIFO_DEPTH = 8,
  parameter int GRP0_FILTS = 2,
  localparam int FW = $clog2(NUM_FILT),
  localparam int BW = $clog2(FIFO_DEPTH),
  localparam int AW = $clog2(NUM_FILT + idf_pkg::NUM_MASK)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [ID_W:0]       wr_data,
  input  logic                fifo_mode,
  input  logic [NUM_FILT-1:0] filt_en,
  input  logic                msg_valid,
  input  logic                msg_ext,
  input  logic [ID_W-1:0]     msg_id,
  output logic                acc_pulse,
  output logic [FW-1:0]       acc_filt,
  output logic [BW-1:0]       acc_buf
);
  logic [NUM_FILT-1:0][ID_W:0]            filt_q;
  logic [idf_pkg::NUM_MASK-1:0][ID_W-1:0] mask_q;
  logic [NUM_FILT-1:0]                    hit;

  idf_regs #(.ID_W(ID_W), .NUM_FILT(NUM_FILT)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .filt_q  (filt_q),
    .mask_q  (mask_q)
  );

  idf_match #(.ID_W(ID_W), .NUM_FILT(NUM_FILT), .GRP0_FILTS(GRP0_FILTS)) u_match (
    .filt_q  (filt_q),
    .mask_q  (mask_q),
    .filt_en (filt_en),
    .msg_ext (msg_ext),
    .msg_id  (msg_id),
    .hit     (hit)
  );

  idf_route #(.NUM_FILT(NUM_FILT), .FIFO_DEPTH(FIFO_DEPTH), .GRP0_FILTS(GRP0_FILTS)) u_route (
    .clk       (clk),
    .rst       (rst),
    .msg_valid (msg_valid),
    .fifo_mode (fifo_mode),
    .filt_en   (filt_en),
    .hit       (hit),
    .acc_pulse (acc_pulse),
    .acc_filt  (acc_filt),
    .acc_buf   (acc_buf)
  );
endmodule

// File: tb/tb_id_accept_filter.sv
module tb_id_accept_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [29:0] wr_data = '0;
  logic        fifo_mode = 1'b0;
  logic [5:0]  filt_en = '0;
  logic        msg_valid = 1'b0;
  logic        msg_ext = 1'b0;
  logic [28:0] msg_id = '0;
  logic        acc_pulse;
  logic [2:0]  acc_filt;
  logic [2:0]  acc_buf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [29:0] mf [6];
  logic [28:0] mm [2];
  logic [2:0]  exp_f = '0;
  logic [2:0]  exp_b = '0;
  logic [2:0]  exp_slot = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  id_accept_filter dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fifo_mode(fifo_mode), .filt_en(filt_en), .msg_valid(msg_valid),
    .msg_ext(msg_ext), .msg_id(msg_id),
    .acc_pulse(acc_pulse), .acc_filt(acc_filt), .acc_buf(acc_buf)
  );

  function automatic bit model_hit(int k, bit ext, logic [28:0] id);
    logic [28:0] sel = ext ? 29'h1FFF_FFFF : {{11{1'b1}}, {18{1'b0}}};
    logic [28:0] m = (k < 2) ? mm[0] : mm[1];
    if (!filt_en[k]) return 1'b0;
    if (mf[k][29] != ext) return 1'b0;
    return ((id ^ mf[k][28:0]) & m & sel) == '0;
  endfunction

  task automatic check(string req, bit p, logic [2:0] f, logic [2:0] b, bit ep, logic [2:0] ef, logic [2:0] eb);
    checks++;
    if (p !== ep || f !== ef || b !== eb) begin
      errors++;
      $display("FAIL %s: pulse/filt/buf actual %0b/%0d/%0d expected %0b/%0d/%0d",
               req, p, f, b, ep, ef, eb);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [29:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 6) mf[a] = d; else mm[a-6] = d[28:0];
  endtask

  task automatic send(string req, bit ext, logic [28:0] id);
    bit ep = 1'b0;
    logic [2:0] idx = '0;
    for (int k = 5; k >= 0; k--) if (model_hit(k, ext, id)) begin ep = 1'b1; idx = 3'(k); end
    if (ep) begin
      exp_f = idx;
      if (fifo_mode) begin
        exp_b = exp_slot;
        exp_slot = exp_slot + 3'd1;
      end else exp_b = (idx >= 2) ? 3'd1 : 3'd0;
    end
    @(negedge clk);
    msg_valid = 1'b1; msg_ext = ext; msg_id = id;
    @(negedge clk);
    msg_valid = 1'b0;
    check(req, acc_pulse, acc_filt, acc_buf, ep, exp_f, exp_b);
    @(negedge clk);
    // R9: pulse lasts one cycle; R12: outputs hold
    check("R9/R12 hold", acc_pulse, acc_filt, acc_buf, 1'b0, exp_f, exp_b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 6; k++) mf[k] = '0;
    mm[0] = '0; mm[1] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 reset", acc_pulse, acc_filt, acc_buf, 1'b0, 3'd0, 3'd0);
    // R1: zeroed registers: std filter 0 with zero mask matches id 0 in legacy
    filt_en = 6'b000001;
    send("R1 zero regs", 1'b0, 29'h0);

    // R3/R4/R5: single-bit flips, standard filter 0
    wr(3'd0, {1'b0, 29'h0ABC_DE00});
    wr(3'd6, {1'b0, 29'h1FFF_FFFF});
    for (int b = 0; b < 29; b++) send("R4/R5 std flip", 1'b0, 29'h0ABC_DE00 ^ (29'h1 << b));
    for (int b = 18; b < 29; b++) begin
      wr(3'd6, {1'b0, 29'h1FFF_FFFF ^ (29'h1 << b)});
      send("R3 std masked bit", 1'b0, 29'h0ABC_DE00 ^ (29'h1 << b));
    end

    // R3/R4/R5: extended filter 1
    wr(3'd1, {1'b1, 29'h1357_9BDF});
    wr(3'd6, {1'b0, 29'h1FFF_FFFF});
    filt_en = 6'b000010;
    send("R4/R5 ext exact", 1'b1, 29'h1357_9BDF);
    for (int b = 0; b < 29; b++) send("R4/R5 ext flip", 1'b1, 29'h1357_9BDF ^ (29'h1 << b));
    for (int b = 0; b < 29; b++) begin
      wr(3'd6, {1'b0, 29'h1FFF_FFFF ^ (29'h1 << b)});
      send("R3 ext masked bit", 1'b1, 29'h1357_9BDF ^ (29'h1 << b));
    end

    // R6: identifier type must agree
    send("R6 std vs ext filter", 1'b0, 29'h1357_9BDF);
    filt_en = 6'b000001;
    send("R6 ext vs std filter", 1'b1, 29'h0ABC_DE00);

    // R7/R8/R10: identical filters, masks cleared, every enable pattern, both modes
    wr(3'd6, 30'h0);
    wr(3'd7, 30'h0);
    for (int k = 0; k < 6; k++) wr(3'(k), {1'b0, 29'h1111_1111});
    for (int md = 0; md < 2; md++) begin
      fifo_mode = md[0];
      for (int e = 0; e < 64; e++) begin
        filt_en = 6'(e);
        send("R7/R8/R10/R11 enable sweep", 1'b0, 29'h0F0F_0F0F);
      end
    end

    // R10: mask grouping: mask 1 strict, mask 0 open
    fifo_mode = 1'b0;
    wr(3'd7, {1'b0, 29'h1FFF_FFFF});
    filt_en = 6'b111100;
    send("R10 mask1 strict miss", 1'b0, 29'h0);
    send("R10 mask1 strict hit", 1'b0, 29'h1111_1111);
    filt_en = 6'b000011;
    send("R10 mask0 open", 1'b0, 29'h0);

    // R11: rejections in FIFO mode leave slot alone
    fifo_mode = 1'b1;
    filt_en = 6'b100000;
    send("R11 reject no advance", 1'b0, 29'h0);
    send("R11 after reject", 1'b0, 29'h1111_1111);

    // Pseudo-random stream against varied filters, both modes
    for (int k = 0; k < 6; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      wr(3'(k), {seed[31], seed[28:0]});
    end
    seed = seed * 32'd1103515245 + 32'd12345;
    wr(3'd6, {1'b0, seed[28:0] | 29'h1FFC_0000});
    seed = seed * 32'd1103515245 + 32'd12345;
    wr(3'd7, {1'b0, seed[28:0]});
    for (int i = 0; i < 300; i++) begin
      logic [28:0] id;
      bit ext;
      int fk;
      seed = seed * 32'd1103515245 + 32'd12345;
      fifo_mode = seed[3];
      filt_en = seed[29:24];
      fk = int'(seed[10:8]) % 6;
      if (seed[5]) begin
        ext = mf[fk][29];
        id = mf[fk][28:0] ^ (29'h1 << seed[20:16]) ^ (seed[4] ? 29'h0 : 29'h1 << seed[15:11]);
      end else begin
        ext = seed[6];
        id = {seed[30:11], seed[31:23]};
      end
      send("R3/R4/R5/R6/R8/R11 random", ext, id);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule